// File: doc/BRIEF.md
# Lane-Mode SIMD Instruction Decoder

This block turns each 18-bit instruction word of a small three-register processor into the control signals the datapath needs. It drives the arithmetic operation, the lane width (one 16-bit lane, two 8-bit lanes or four 4-bit lanes), the register selects, the immediate and the memory strobes. It also owns the program counter, a hardware loop counter and the halt state. Every arithmetic and logic operation occupies three adjacent opcodes, one per lane width. Decoding is combinational from `instr_i`, so the word fetched at `pc_o` must arrive in the same cycle.

A zero-overhead loop uses two instructions. One instruction loads the loop counter from its immediate. A looping jump goes back to its immediate address while the counter is nonzero and decrements it on each pass. A halt instruction freezes the program counter and raises `done_o` until the next reset. Instruction and data memories, each 1024 words deep, are outside the block.

Top module: `simd_decoder`

## Requirements
- R1: The opcode is `instr_i[17:12]`. For opcodes 0..35, the group is opcode/3 and the lane is opcode mod 3, with `lane_o` 0 = 16-bit, 1 = 8-bit and 2 = 4-bit. `lane_o` never reads 3. The group gives `alu_op_o`: 0 add, 1 add-imm, 2 sub, 3 sub-imm, 4 mul, 5 mul-imm, 6 MAC, 7 shift-left, 8 shift-right, 9 AND, 10 OR, 11 NOT. The `alu_op_o` codes are NOP=0, ADD=1, SUB=2, MUL=3, MAC=4, SHL=5, SHR=6, AND=7, OR=8, NOT=9, SET=10.
- R2: The two-register form covers add, sub, mul, AND and OR. It sets `dst_sel_o` and `src_a_sel_o` to bits 3:2 and `src_b_sel_o` to bits 1:0. It drives `use_imm_o`=0, `imm_o`=0 and `reg_we_o`=1.
- R3: The immediate form covers add-imm, sub-imm, mul-imm, load (38..40), store (41..43) and set (44..46). It sets `dst_sel_o` and `src_a_sel_o` to bits 11:10, `src_b_sel_o` to 0, `imm_o` to bits 9:0 and `use_imm_o` to 1.
- R4: Shift-left, shift-right and NOT set `dst_sel_o` and `src_a_sel_o` to bits 1:0, with `src_b_sel_o`=0. MAC sets `dst_sel_o` (the accumulator) to bits 5:4, `src_a_sel_o` to bits 3:2 and `src_b_sel_o` to bits 1:0. All of these drive `reg_we_o`=1.
- R5: Load drives `mem_en_o`=1, `mem_we_o`=0, `reg_we_o`=1 and `load_full_o`=1, with `alu_op_o`=NOP. Store drives `mem_en_o`=1, `mem_we_o`=1 and `reg_we_o`=0. For both, `mem_addr_o` equals bits 9:0. Otherwise `mem_addr_o` is 0, and `mem_we_o` and `reg_we_o` are never high together.
- R6: Set drives `alu_op_o`=SET, `reg_we_o`=1 and the lane mode of its opcode.
- R7: The program counter advances by one each cycle for every instruction that is not a taken looping jump or a halt.
- R8: Setloop (37) loads the loop counter from bits 9:0. The looping jump (36) goes to bits 9:0 and decrements the counter when the counter is nonzero, and falls through to PC+1 when it is zero. Both output `imm_o` = bits 9:0 and have no strobes.
- R9: Halt (63) raises `done_o` from the next cycle on and holds `pc_o` at the halt address until reset.
- R10: Opcodes 47..62 act as no-ops: `alu_op_o`=NOP, every strobe, select and immediate is 0, and the PC advances.
- R11: An active-low `rst_ni` asynchronously clears the program counter, the loop counter and `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 18 | Instruction word fetched at `pc_o` |
| pc_o | output | 10 | Program counter / instruction address |
| alu_op_o | output | 4 | Datapath operation code |
| lane_o | output | 2 | Lane mode: 0 16-bit, 1 8-bit, 2 4-bit |
| dst_sel_o | output | 2 | Destination register select |
| src_a_sel_o | output | 2 | First source register select |
| src_b_sel_o | output | 2 | Second source register select |
| imm_o | output | 10 | Immediate field |
| use_imm_o | output | 1 | Operand B comes from `imm_o` |
| mem_en_o | output | 1 | Data memory access strobe |
| mem_we_o | output | 1 | Data memory write strobe |
| mem_addr_o | output | 10 | Data memory address |
| reg_we_o | output | 1 | Register file write enable |
| load_full_o | output | 1 | Write the full memory word regardless of lane |
| done_o | output | 1 | Program halted |

## Verification
Decode errors show in the same cycle, because the outputs follow `instr_i` with no register in between. A bad loop counter never reaches a port directly. It shows only at the looping jump, where `pc_o` goes to the wrong address on the next edge. For that reason the program jumps once with a counter just cleared by reset and runs three passes of a loop. A stuck or early `done_o` shows as a frozen or still-moving `pc_o` one cycle after the halt.

// File: rtl/simd_dec_pkg.sv
package simd_dec_pkg;
  localparam int OP_W  = 6;
  localparam int SEL_W = 2;

  typedef enum logic [3:0] {
    ALU_NOP = 4'd0, ALU_ADD = 4'd1, ALU_SUB = 4'd2, ALU_MUL = 4'd3,
    ALU_MAC = 4'd4, ALU_SHL = 4'd5, ALU_SHR = 4'd6, ALU_AND = 4'd7,
    ALU_OR  = 4'd8, ALU_NOT = 4'd9, ALU_SET = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {LANE_16 = 2'd0, LANE_8 = 2'd1, LANE_4 = 2'd2} lane_e;

  localparam logic [OP_W-1:0] OP_GRP_END = 6'd36;
  localparam logic [OP_W-1:0] OP_LJMP    = 6'd36;
  localparam logic [OP_W-1:0] OP_SETLOOP = 6'd37;
  localparam logic [OP_W-1:0] OP_LOAD    = 6'd38;
  localparam logic [OP_W-1:0] OP_STORE   = 6'd41;
  localparam logic [OP_W-1:0] OP_SET     = 6'd44;
  localparam logic [OP_W-1:0] OP_HALT    = 6'd63;

  typedef struct packed {
    alu_op_e          alu;
    lane_e            lane;
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic             use_imm;
    logic             imm_out;
    logic             mem_en;
    logic             mem_we;
    logic             reg_we;
    logic             load_full;
    logic             ljmp;
    logic             setloop;
    logic             halt;
  } ctrl_t;

  // group index (opcode / 3) to datapath operation
  function automatic alu_op_e grp_alu(input logic [3:0] grp);
    case (grp)
      4'd0, 4'd1: grp_alu = ALU_ADD;
      4'd2, 4'd3: grp_alu = ALU_SUB;
      4'd4, 4'd5: grp_alu = ALU_MUL;
      4'd6:       grp_alu = ALU_MAC;
      4'd7:       grp_alu = ALU_SHL;
      4'd8:       grp_alu = ALU_SHR;
      4'd9:       grp_alu = ALU_AND;
      4'd10:      grp_alu = ALU_OR;
      default:    grp_alu = ALU_NOT;
    endcase
  endfunction
endpackage

// File: rtl/simd_dec_field.sv
module simd_dec_field
  import simd_dec_pkg::*;
#(
  parameter int INSTR_W = 18,
  parameter int IMM_W   = 10
) (
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              ctrl_o,
  output logic [IMM_W-1:0]   imm_o
);
  localparam int HI_LSB  = IMM_W;  // register select of immediate form
  localparam int ACC_LSB = 4;
  localparam int RA_LSB  = 2;

  logic [OP_W-1:0]  op;
  logic [3:0]       grp;
  logic [1:0]       lane_v;
  logic [SEL_W-1:0] sel_hi, sel_acc, sel_a, sel_b;

  assign op      = instr_i[INSTR_W-1 -: OP_W];
  assign grp     = 4'(op / 6'd3);
  assign lane_v  = 2'(op - 6'(grp) * 6'd3);
  assign sel_hi  = instr_i[HI_LSB +: SEL_W];
  assign sel_acc = instr_i[ACC_LSB +: SEL_W];
  assign sel_a   = instr_i[RA_LSB +: SEL_W];
  assign sel_b   = instr_i[SEL_W-1:0];

  always_comb begin
    ctrl_o      = '0;
    ctrl_o.alu  = ALU_NOP;
    ctrl_o.lane = LANE_16;
    if (op < OP_GRP_END) begin
      ctrl_o.alu    = grp_alu(grp);
      ctrl_o.lane   = lane_e'(lane_v);
      ctrl_o.reg_we = 1'b1;
      case (grp)
        4'd1, 4'd3, 4'd5: begin
          ctrl_o.dst = sel_hi; ctrl_o.src_a = sel_hi;
          ctrl_o.use_imm = 1'b1; ctrl_o.imm_out = 1'b1;
        end
        4'd6: begin
          ctrl_o.dst = sel_acc; ctrl_o.src_a = sel_a; ctrl_o.src_b = sel_b;
        end
        4'd7, 4'd8, 4'd11: begin
          ctrl_o.dst = sel_b; ctrl_o.src_a = sel_b;
        end
        default: begin
          ctrl_o.dst = sel_a; ctrl_o.src_a = sel_a; ctrl_o.src_b = sel_b;
        end
      endcase
    end else if (op >= OP_LOAD && op < OP_SET + 6'd3) begin
      ctrl_o.dst     = sel_hi;
      ctrl_o.src_a   = sel_hi;
      ctrl_o.use_imm = 1'b1;
      ctrl_o.imm_out = 1'b1;
      if (op < OP_STORE) begin
        ctrl_o.lane      = lane_e'(2'(op - OP_LOAD));
        ctrl_o.mem_en    = 1'b1;
        ctrl_o.reg_we    = 1'b1;
        ctrl_o.load_full = 1'b1;
      end else if (op < OP_SET) begin
        ctrl_o.lane   = lane_e'(2'(op - OP_STORE));
        ctrl_o.mem_en = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end else begin
        ctrl_o.lane   = lane_e'(2'(op - OP_SET));
        ctrl_o.alu    = ALU_SET;
        ctrl_o.reg_we = 1'b1;
      end
    end else if (op == OP_LJMP) begin
      ctrl_o.ljmp = 1'b1; ctrl_o.imm_out = 1'b1;
    end else if (op == OP_SETLOOP) begin
      ctrl_o.setloop = 1'b1; ctrl_o.imm_out = 1'b1;
    end else if (op == OP_HALT) begin
      ctrl_o.halt = 1'b1;
    end
  end

  assign imm_o = ctrl_o.imm_out ? instr_i[IMM_W-1:0] : '0;
endmodule

// File: rtl/simd_dec_seq.sv
module simd_dec_seq #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ljmp_i,
  input  logic              setloop_i,
  input  logic              halt_i,
  input  logic [ADDR_W-1:0] imm_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] pc_q, cnt_q;
  logic              done_q, taken;

  // counter tested before decrement
  assign taken = ljmp_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (halt_i) begin
        done_q <= 1'b1;
      end else if (taken) begin
        pc_q  <= imm_i;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
        if (setloop_i) cnt_q <= imm_i;
      end
    end
  end

  assign pc_o   = pc_q;
  assign done_o = done_q;

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q); // R9
  AST_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || halt_i) |=> pc_q == $past(pc_q)); // R9
  AST_LOOP_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ljmp_i && cnt_q != '0 && !done_q) |=> pc_q == $past(imm_i)); // R8
  AST_LOOP_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ljmp_i && cnt_q == '0 && !done_q) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R8
endmodule

// File: rtl/simd_decoder.sv
module simd_decoder
  import simd_dec_pkg::*;
#(
  parameter int INSTR_W = 18,
  parameter int ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [3:0]         alu_op_o,
  output logic [1:0]         lane_o,
  output logic [1:0]         dst_sel_o,
  output logic [1:0]         src_a_sel_o,
  output logic [1:0]         src_b_sel_o,
  output logic [ADDR_W-1:0]  imm_o,
  output logic               use_imm_o,
  output logic               mem_en_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               reg_we_o,
  output logic               load_full_o,
  output logic               done_o
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] imm;

  simd_dec_field #(.INSTR_W(INSTR_W), .IMM_W(ADDR_W)) u_field (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .imm_o   (imm)
  );

  simd_dec_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ljmp_i    (ctrl.ljmp),
    .setloop_i (ctrl.setloop),
    .halt_i    (ctrl.halt),
    .imm_i     (imm),
    .pc_o      (pc_o),
    .done_o    (done_o)
  );

  assign alu_op_o    = ctrl.alu;
  assign lane_o      = ctrl.lane;
  assign dst_sel_o   = ctrl.dst;
  assign src_a_sel_o = ctrl.src_a;
  assign src_b_sel_o = ctrl.src_b;
  assign imm_o       = imm;
  assign use_imm_o   = ctrl.use_imm;
  assign mem_en_o    = ctrl.mem_en;
  assign mem_we_o    = ctrl.mem_we;
  assign mem_addr_o  = ctrl.mem_en ? imm : '0;
  assign reg_we_o    = ctrl.reg_we;
  assign load_full_o = ctrl.load_full;

  AST_WE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o); // R5
  AST_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && reg_we_o)); // R5
  AST_LANE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_o != 2'd3); // R1
  AST_FULL_IS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_full_o |-> (mem_en_o && !mem_we_o && use_imm_o)); // R5
endmodule

// File: tb/simd_decoder_bench.sv
`timescale 1ns/1ps
module simd_decoder_bench;
  localparam real CLK_PER = 20.0;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] instr;
  logic [9:0]  pc, imm, maddr;
  logic [3:0]  alu;
  logic [1:0]  lane, dst, sa, sb;
  logic        ui, men, mwe, rwe, lfull, done;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [47:0] vec;
    string       tag;
  } item_t;
  item_t sb_q[$];

  logic [17:0] prog [16];

  always #(CLK_PER/2.0) clk = ~clk;

  always_comb instr = (pc < 10'd16) ? prog[pc[3:0]] : 18'h0;

  simd_decoder u_simd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .pc_o(pc),
    .alu_op_o(alu), .lane_o(lane), .dst_sel_o(dst), .src_a_sel_o(sa),
    .src_b_sel_o(sb), .imm_o(imm), .use_imm_o(ui), .mem_en_o(men),
    .mem_we_o(mwe), .mem_addr_o(maddr), .reg_we_o(rwe),
    .load_full_o(lfull), .done_o(done)
  );

  function automatic logic [47:0] ev(int p, int a, int l, int d, int x, int y,
                                     int u, int im, int en, int we, int rw,
                                     int ad, int lf, int dn);
    ev = {10'(p), 4'(a), 2'(l), 2'(d), 2'(x), 2'(y), 1'(u), 10'(im),
          1'(en), 1'(we), 1'(rw), 10'(ad), 1'(lf), 1'(dn)};
  endfunction

  function automatic logic [47:0] act();
    act = {pc, alu, lane, dst, sa, sb, ui, imm, men, mwe, rwe, maddr, lfull, done};
  endfunction

  task automatic check(string tag, logic [47:0] a, logic [47:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, a, e);
    end
  endtask

  // driver side: push expected results
  task automatic push(string tag, logic [47:0] v);
    item_t it;
    it.vec = v;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor side: pop and compare one item per cycle, away from posedge
  task automatic drain();
    while (sb_q.size() > 0) begin
      item_t it;
      #1;
      it = sb_q.pop_front();
      check(it.tag, act(), it.vec);
      @(negedge clk);
    end
  endtask

  initial begin
    prog[0]  = {6'd36, 2'd0, 10'd5};          // loopjump, counter zero
    prog[1]  = {6'd37, 2'd0, 10'd2};          // setloop 2
    prog[2]  = {6'd1, 8'd0, 2'd1, 2'd2};      // add8 R1,R2
    prog[3]  = {6'd11, 2'd2, 10'd5};          // subi4 R2,#5
    prog[4]  = {6'd18, 6'd0, 2'd0, 2'd1, 2'd2}; // mac16 R0+=R1*R2
    prog[5]  = {6'd22, 10'd0, 2'd2};          // shl8 R2
    prog[6]  = {6'd36, 2'd0, 10'd2};          // loopjump 2
    prog[7]  = {6'd40, 2'd1, 10'd7};          // load4 R1,@7
    prog[8]  = {6'd41, 2'd0, 10'd9};          // store16 R0,@9
    prog[9]  = {6'd45, 2'd1, 10'h05A};        // set8 R1
    prog[10] = {6'd50, 12'hFFF};              // undefined
    prog[11] = {6'd35, 12'd0};                // not4 R0
    prog[12] = {6'd30, 8'd0, 2'd2, 2'd1};     // or16 R2,R1
    prog[13] = {6'd37, 2'd0, 10'd3};          // setloop 3
    prog[14] = {6'd63, 12'd0};                // halt
    prog[15] = 18'h0;
  end

  initial begin
    #(CLK_PER * 5000);
    n_fail++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R11 reset pc/done", {38'd0, pc}, {38'd0, 10'd0});
    check("R11 reset done", {47'd0, done}, 48'd0);

    push("R8 R11 jump with zero counter", ev(0,0,0,0,0,0,0,5,0,0,0,0,0,0));
    push("R8 setloop",                    ev(1,0,0,0,0,0,0,2,0,0,0,0,0,0));
    for (int k = 0; k < 3; k++) begin
      push("R2 R1 add8 reg-reg",   ev(2,1,1,1,1,2,0,0,0,0,1,0,0,0));
      push("R3 R1 subi4",          ev(3,2,2,2,2,0,1,5,0,0,1,0,0,0));
      push("R4 mac16",             ev(4,4,0,0,1,2,0,0,0,0,1,0,0,0));
      push("R4 R7 shl8",           ev(5,5,1,2,2,0,0,0,0,0,1,0,0,0));
      push("R8 loopjump",          ev(6,0,0,0,0,0,0,2,0,0,0,0,0,0));
    end
    push("R5 load4 after loop exit", ev(7,0,2,1,1,0,1,7,1,0,1,7,1,0));
    push("R5 store16",             ev(8,0,0,0,0,0,1,9,1,1,0,9,0,0));
    push("R6 set8",                ev(9,10,1,1,1,0,1,'h5A,0,0,1,0,0,0));
    push("R10 undefined opcode",   ev(10,0,0,0,0,0,0,0,0,0,0,0,0,0));
    push("R10 R4 not4 after no-op", ev(11,9,2,0,0,0,0,0,0,0,1,0,0,0));
    push("R2 or16",                ev(12,8,0,2,2,1,0,0,0,0,1,0,0,0));
    push("R8 setloop before halt", ev(13,0,0,0,0,0,0,3,0,0,0,0,0,0));
    push("R9 halt decode",         ev(14,0,0,0,0,0,0,0,0,0,0,0,0,0));
    for (int k = 0; k < 3; k++)
      push("R9 halted",            ev(14,0,0,0,0,0,0,0,0,0,0,0,0,1));

    @(negedge clk);
    rst_ni = 1'b1;
    drain();

    rst_ni = 1'b0;
    #1;
    check("R11 mid-run reset pc", {38'd0, pc}, 48'd0);
    check("R11 mid-run reset done", {47'd0, done}, 48'd0);
    @(negedge clk);
    push("R11 restart",                      ev(0,0,0,0,0,0,0,5,0,0,0,0,0,0));
    push("R11 loop counter cleared by reset", ev(1,0,0,0,0,0,0,2,0,0,0,0,0,0));
    push("R7 advance",                       ev(2,1,1,1,1,2,0,0,0,0,1,0,0,0));
    rst_ni = 1'b1;
    drain();

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule